// File: doc/BRIEF.md
# SPI-Mode Card Data Phase Engine

This block runs the data phase of a memory card that speaks SPI mode, one byte per SPI transfer. A companion command parser tells it when a read command has been answered and whether the read is single-block or multi-block. From then on the engine answers each host byte itself. It sends a start token, streams data bytes from a back-end byte source and appends a CRC16 that it accumulates while streaming. For multi-block reads it keeps chaining blocks until the host sends the stop command byte.

In command mode it also watches for the write start tokens. Once a token arrives, it hands the following bytes to a back-end sink, drops the two host CRC bytes without checking them, and answers with a data-accepted byte. The stop token for multi-block writes raises a stop request towards the back end. The transfer after it reports the back end's busy state. The engine responds one clock after each transfer strobe, and the `in_cmd_mode` output tells the companion parser when host bytes are commands.

Top module: `sdspi_data_phase`

## Requirements
- R1: After reset, `tx_valid` is 0, `tx_byte` is 0xFF and `in_cmd_mode` is 1.
- R2: Every cycle with `xfer_valid` high produces `tx_valid` high in the next cycle, and `tx_valid` is low otherwise. In command mode, any byte other than 0xFE, 0xFC or 0xFD is answered with 0xFF and leaves the engine in command mode. This includes 0x4C, which raises no `rd_abort` there.
- R3: A `rd_start` pulse in command mode leaves command mode. The next transfer answers the start token 0xFE. Each following transfer answers `be_rd_data` and pulses `be_rd_pop` once, in back-end order. A block ends after the byte flagged by `be_rd_last` or after BLOCK_BYTES (512) bytes, whichever comes first.
- R4: The two transfers after a read block's last data byte return the CRC16 of that block's data bytes, high byte first. The CRC uses polynomial 0x1021 with initial value 0x0000, bits taken most significant first. The CRC restarts for every block.
- R5: After the CRC, a block that held the full 512 bytes and was started with `rd_single` low is followed by one 0xFF gap transfer and then a new 0xFE token and block. Every other block returns the engine to command mode.
- R6: The byte 0x4C received in any read state (gap, token, data or CRC) is answered with 0xFF, pulses `rd_abort`, pops no data and returns the engine to command mode.
- R7: In command mode, 0xFE or 0xFC is answered with 0xFF and starts a write block, leaving command mode.
- R8: Each write data byte is echoed on `tx_byte` and passed on `be_wr_data` with a one-cycle `be_wr_valid` pulse. This continues until the byte sent while `be_wr_last` is high, or until 512 bytes. Any byte value, 0x4C included, counts as data here.
- R9: The two transfers after the last write data byte are answered with 0xFF and are not passed to the back end. The next transfer is answered with 0x05, and the engine then returns to command mode.
- R10: In command mode, 0xFD is answered with 0xFF and pulses `be_stop`. The next transfer is answered with 0x00 if `be_busy` is high and with 0xFF if it is low, and the engine then returns to command mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid | input | 1 | One-cycle strobe: a host byte is on `rx_byte` |
| rx_byte | input | 8 | Byte received from the host |
| tx_valid | output | 1 | Reply byte valid, one cycle after `xfer_valid` |
| tx_byte | output | 8 | Reply byte for the host |
| rd_start | input | 1 | Companion parser: read command answered, begin data phase |
| rd_single | input | 1 | With `rd_start`: 1 for single-block read |
| rd_abort | output | 1 | Pulse: stop command byte seen during a read |
| in_cmd_mode | output | 1 | High while host bytes are commands |
| be_rd_data | input | 8 | Current byte from the back-end source |
| be_rd_last | input | 1 | Current source byte is the last available |
| be_rd_pop | output | 1 | Pulse: current source byte consumed |
| be_wr_valid | output | 1 | Pulse: write byte on `be_wr_data` |
| be_wr_data | output | 8 | Write byte towards the back-end sink |
| be_wr_last | input | 1 | Sink takes no more bytes after the current one |
| be_stop | output | 1 | Pulse: stop request to the back end |
| be_busy | input | 1 | Back end busy, reported after a stop token |

## Verification
Each reply is registered, so the reply to a byte presented with `xfer_valid` is due exactly one clock later. The bench raises the strobe at a falling edge and reads `tx_byte` at the next falling edge, just after the registering edge. The back-end pulses (`be_rd_pop`, `be_wr_valid`, `be_stop`, `rd_abort`) occur in the same cycle as the strobe. The bench counts them at that rising edge and compares the totals after the transfer. Read data and CRC values are predicted from the bench's own source pattern and its own bit-serial CRC routine.

// File: rtl/sdspi_dp_pkg.sv
package sdspi_dp_pkg;

    localparam logic [7:0] BYTE_IDLE      = 8'hFF;
    localparam logic [7:0] TOK_BLOCK      = 8'hFE;
    localparam logic [7:0] TOK_MULTI_WR   = 8'hFC;
    localparam logic [7:0] TOK_STOP_WR    = 8'hFD;
    localparam logic [7:0] BYTE_ABORT_CMD = 8'h4C;
    localparam logic [7:0] BYTE_ACCEPTED  = 8'h05;
    localparam logic [7:0] BYTE_BUSY      = 8'h00;

    typedef enum logic [3:0] {
        PH_CMD,
        PH_RD_GAP,
        PH_RD_TOKEN,
        PH_RD_DATA,
        PH_RD_CRC,
        PH_WR_DATA,
        PH_WR_CRC,
        PH_WR_RESP,
        PH_STOP_STAT
    } phase_e;

    typedef struct packed {
        phase_e      phase;
        logic [15:0] crc;
        logic        single;
        logic        full;
        logic        half;
        logic        tx_vld;
        logic [7:0]  tx;
    } dp_state_t;

    localparam dp_state_t DP_RESET = '{
        phase:  PH_CMD,
        crc:    16'h0000,
        single: 1'b0,
        full:   1'b0,
        half:   1'b0,
        tx_vld: 1'b0,
        tx:     BYTE_IDLE
    };

endpackage

// File: rtl/sdspi_crc16_step.sv
module sdspi_crc16_step #(
    parameter logic [15:0] POLY = 16'h1021,
    parameter int          DW   = 8
) (
    input  logic [15:0]   crc_in,
    input  logic [DW-1:0] data_in,
    output logic [15:0]   crc_out
);
    logic [15:0] stage [0:DW];

    assign stage[0] = crc_in ^ {data_in, {(16-DW){1'b0}}};

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign stage[i+1] = stage[i][15] ? ((stage[i] << 1) ^ POLY)
                                         : (stage[i] << 1);
    end

    assign crc_out = stage[DW];
endmodule

// File: rtl/sdspi_byte_ctr.sv
module sdspi_byte_ctr #(
    parameter int LIMIT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int CW = $clog2(LIMIT) + 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/sdspi_token_decode.sv
module sdspi_token_decode
    import sdspi_dp_pkg::*;
(
    input  logic [7:0] byte_in,
    output logic       is_wr_start,
    output logic       is_wr_stop,
    output logic       is_abort
);
    always_comb begin
        is_wr_start = (byte_in == TOK_BLOCK) || (byte_in == TOK_MULTI_WR);
        is_wr_stop  = (byte_in == TOK_STOP_WR);
        is_abort    = (byte_in == BYTE_ABORT_CMD);
    end
endmodule

// File: rtl/sdspi_data_phase.sv
module sdspi_data_phase
    import sdspi_dp_pkg::*;
#(
    parameter int          BLOCK_BYTES = 512,
    parameter logic [15:0] CRC_POLY    = 16'h1021
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer_valid,
    input  logic [7:0] rx_byte,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    input  logic       rd_start,
    input  logic       rd_single,
    output logic       rd_abort,
    output logic       in_cmd_mode,
    input  logic [7:0] be_rd_data,
    input  logic       be_rd_last,
    output logic       be_rd_pop,
    output logic       be_wr_valid,
    output logic [7:0] be_wr_data,
    input  logic       be_wr_last,
    output logic       be_stop,
    input  logic       be_busy
);
    dp_state_t st_d, st_q;

    logic        tok_wr_start, tok_wr_stop, tok_abort;
    logic [15:0] crc_next;
    logic        cnt_clr, cnt_inc, cnt_last;
    logic        in_read;

    sdspi_token_decode u_tok (
        .byte_in     (rx_byte),
        .is_wr_start (tok_wr_start),
        .is_wr_stop  (tok_wr_stop),
        .is_abort    (tok_abort)
    );

    sdspi_crc16_step #(.POLY(CRC_POLY), .DW(8)) u_crc (
        .crc_in  (st_q.crc),
        .data_in (be_rd_data),
        .crc_out (crc_next)
    );

    sdspi_byte_ctr #(.LIMIT(BLOCK_BYTES)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .at_last (cnt_last)
    );

    always_comb begin
        in_read = (st_q.phase == PH_RD_GAP)   || (st_q.phase == PH_RD_TOKEN) ||
                  (st_q.phase == PH_RD_DATA)  || (st_q.phase == PH_RD_CRC);
    end

    always_comb begin
        st_d        = st_q;
        st_d.tx_vld = 1'b0;
        cnt_clr     = 1'b0;
        cnt_inc     = 1'b0;
        rd_abort    = 1'b0;
        be_rd_pop   = 1'b0;
        be_wr_valid = 1'b0;
        be_stop     = 1'b0;

        if (rd_start && st_q.phase == PH_CMD) begin
            // Data phase begins; a coincident host byte gets a filler reply.
            st_d.phase  = PH_RD_TOKEN;
            st_d.single = rd_single;
            st_d.full   = 1'b0;
            if (xfer_valid) begin
                st_d.tx_vld = 1'b1;
                st_d.tx     = BYTE_IDLE;
            end
        end else if (xfer_valid) begin
            st_d.tx_vld = 1'b1;
            st_d.tx     = BYTE_IDLE;
            if (in_read && tok_abort) begin
                st_d.phase = PH_CMD;
                rd_abort   = 1'b1;
            end else begin
                unique case (st_q.phase)
                    PH_CMD: begin
                        if (tok_wr_start) begin
                            st_d.phase = PH_WR_DATA;
                            cnt_clr    = 1'b1;
                        end else if (tok_wr_stop) begin
                            st_d.phase = PH_STOP_STAT;
                            be_stop    = 1'b1;
                        end
                    end
                    PH_STOP_STAT: begin
                        st_d.tx    = be_busy ? BYTE_BUSY : BYTE_IDLE;
                        st_d.phase = PH_CMD;
                    end
                    PH_RD_GAP: begin
                        st_d.phase = PH_RD_TOKEN;
                    end
                    PH_RD_TOKEN: begin
                        st_d.tx    = TOK_BLOCK;
                        st_d.crc   = 16'h0000;
                        st_d.full  = 1'b0;
                        cnt_clr    = 1'b1;
                        st_d.phase = PH_RD_DATA;
                    end
                    PH_RD_DATA: begin
                        st_d.tx   = be_rd_data;
                        st_d.crc  = crc_next;
                        be_rd_pop = 1'b1;
                        cnt_inc   = 1'b1;
                        if (be_rd_last || cnt_last) begin
                            st_d.phase = PH_RD_CRC;
                            st_d.full  = cnt_last;
                            st_d.half  = 1'b0;
                        end
                    end
                    PH_RD_CRC: begin
                        if (!st_q.half) begin
                            st_d.tx   = st_q.crc[15:8];
                            st_d.half = 1'b1;
                        end else begin
                            st_d.tx   = st_q.crc[7:0];
                            st_d.half = 1'b0;
                            cnt_clr   = 1'b1;
                            st_d.phase = (st_q.full && !st_q.single) ? PH_RD_GAP
                                                                      : PH_CMD;
                        end
                    end
                    PH_WR_DATA: begin
                        st_d.tx     = rx_byte;
                        be_wr_valid = 1'b1;
                        cnt_inc     = 1'b1;
                        if (be_wr_last || cnt_last) begin
                            st_d.phase = PH_WR_CRC;
                            st_d.half  = 1'b0;
                        end
                    end
                    PH_WR_CRC: begin
                        if (!st_q.half) begin
                            st_d.half = 1'b1;
                        end else begin
                            st_d.half  = 1'b0;
                            cnt_clr    = 1'b1;
                            st_d.phase = PH_WR_RESP;
                        end
                    end
                    PH_WR_RESP: begin
                        st_d.tx    = BYTE_ACCEPTED;
                        st_d.phase = PH_CMD;
                    end
                    default: begin
                        st_d.phase = PH_CMD;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= DP_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid    = st_q.tx_vld;
    assign tx_byte     = st_q.tx;
    assign in_cmd_mode = (st_q.phase == PH_CMD);
    assign be_wr_data  = rx_byte;
endmodule

// File: rtl/sdspi_data_phase_chk.sv
module sdspi_data_phase_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       xfer_valid,
    input logic       tx_valid,
    input logic [7:0] tx_byte,
    input logic       rd_start,
    input logic       rd_abort,
    input logic       in_cmd_mode,
    input logic       be_rd_pop,
    input logic       be_wr_valid,
    input logic [7:0] be_wr_data,
    input logic       be_stop
);
    AST_TX_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> tx_valid); // R2
    AST_NO_TX_WITHOUT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_valid |=> !tx_valid); // R2
    AST_MODE_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_valid && !rd_start) |=> $stable(in_cmd_mode)); // R2
    AST_READ_LEAVES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && in_cmd_mode) |=> !in_cmd_mode); // R3
    AST_POP_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        be_rd_pop |-> xfer_valid); // R3
    AST_ABORT_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_abort |=> (in_cmd_mode && tx_byte == 8'hFF)); // R6
    AST_ABORT_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_abort |-> !be_rd_pop); // R6
    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(be_rd_pop && be_wr_valid)); // R8
    AST_WR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        be_wr_valid |=> (tx_byte == $past(be_wr_data))); // R8
    AST_STOP_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        be_stop |=> (tx_byte == 8'hFF && !in_cmd_mode)); // R10
endmodule

bind sdspi_data_phase sdspi_data_phase_chk u_chk (.*);

// File: tb/sdspi_data_phase_bench.sv
`timescale 1ns/1ps
module sdspi_data_phase_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_valid = 1'b0;
    logic [7:0] rx_byte = 8'hFF;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       rd_start = 1'b0;
    logic       rd_single = 1'b0;
    logic       rd_abort;
    logic       in_cmd_mode;
    logic [7:0] be_rd_data;
    logic       be_rd_last;
    logic       be_rd_pop;
    logic       be_wr_valid;
    logic [7:0] be_wr_data;
    logic       be_wr_last;
    logic       be_stop;
    logic       be_busy = 1'b0;

    always #2 clk = ~clk;

    sdspi_data_phase u_sdspi_data_phase (
        .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .rx_byte(rx_byte),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .rd_start(rd_start),
        .rd_single(rd_single), .rd_abort(rd_abort), .in_cmd_mode(in_cmd_mode),
        .be_rd_data(be_rd_data), .be_rd_last(be_rd_last), .be_rd_pop(be_rd_pop),
        .be_wr_valid(be_wr_valid), .be_wr_data(be_wr_data),
        .be_wr_last(be_wr_last), .be_stop(be_stop), .be_busy(be_busy)
    );

    // Back-end models
    logic [7:0] rd_base = 8'h30;
    int rd_idx = 0;
    int rd_stop = 0;     // absolute index after which the source is empty; 0 = none
    int wr_cnt = 0;
    int wr_stop = 0;     // absolute count at which the sink is full; 0 = none
    logic [7:0] wr_log [0:1023];
    int abort_cnt = 0;
    int stop_cnt = 0;

    assign be_rd_data = rd_base + rd_idx[7:0];
    assign be_rd_last = (rd_stop != 0) && (rd_idx == rd_stop - 1);
    assign be_wr_last = (wr_stop != 0) && (wr_cnt == wr_stop - 1);

    always @(posedge clk) begin
        if (be_rd_pop) rd_idx <= rd_idx + 1;
        if (be_wr_valid) begin
            wr_log[wr_cnt[9:0]] <= be_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (rd_abort) abort_cnt <= abort_cnt + 1;
        if (be_stop) stop_cnt <= stop_cnt + 1;
    end

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int b = 7; b >= 0; b--) begin
            logic fb = r[15] ^ d[b];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        @(negedge clk);
        rx_byte = b;
        xfer_valid = 1'b1;
        @(negedge clk);
        xfer_valid = 1'b0;
        rx_byte = 8'hFF;
        r = tx_byte;
        chk(tx_valid === 1'b1, "R2 tx_valid after transfer", tx_valid, 1);
    endtask

    task automatic start_read(input logic single);
        @(negedge clk);
        rd_start = 1'b1;
        rd_single = single;
        @(negedge clk);
        rd_start = 1'b0;
        chk(!in_cmd_mode, "R3 left command mode", in_cmd_mode, 0);
    endtask

    // Reads token, n data bytes and CRC; checks all of them.
    task automatic read_block(input int n);
        logic [7:0] r;
        logic [15:0] c = 16'h0000;
        int bad = 0;
        xfer(8'hFF, r);
        chk(r == 8'hFE, "R3 start token", r, 8'hFE);
        for (int k = 0; k < n; k++) begin
            logic [7:0] e = rd_base + rd_idx[7:0];
            xfer(8'hFF, r);
            c = crc_add(c, e);
            if (r != e) begin
                bad++;
                chk(1'b0, "R3 read data byte", r, e);
            end
        end
        chk(bad == 0, "R3 block data", bad, 0);
        xfer(8'hFF, r);
        chk(r == c[15:8], "R4 crc high", r, c[15:8]);
        xfer(8'hFF, r);
        chk(r == c[7:0], "R4 crc low", r, c[7:0]);
    endtask

    task automatic t_reset();
        chk(tx_valid == 1'b0, "R1 tx_valid reset", tx_valid, 0);
        chk(tx_byte == 8'hFF, "R1 tx_byte reset", tx_byte, 8'hFF);
        chk(in_cmd_mode == 1'b1, "R1 cmd mode reset", in_cmd_mode, 1);
    endtask

    task automatic t_idle();
        logic [7:0] r;
        int a0 = abort_cnt;
        xfer(8'h00, r); chk(r == 8'hFF, "R2 idle reply 00", r, 8'hFF);
        xfer(8'h51, r); chk(r == 8'hFF, "R2 idle reply 51", r, 8'hFF);
        xfer(8'h4C, r); chk(r == 8'hFF, "R2 idle reply 4C", r, 8'hFF);
        chk(abort_cnt == a0, "R2 no abort in cmd mode", abort_cnt, a0);
        chk(in_cmd_mode, "R2 stays in cmd mode", in_cmd_mode, 1);
        @(negedge clk);
        chk(!tx_valid, "R2 no reply without transfer", tx_valid, 0);
    endtask

    task automatic t_short_read();
        rd_stop = rd_idx + 5;
        start_read(1'b1);
        read_block(5);
        chk(in_cmd_mode, "R5 short block back to cmd", in_cmd_mode, 1);
        rd_stop = 0;
    endtask

    task automatic t_multi_read();
        logic [7:0] r;
        int i0;
        start_read(1'b0);
        read_block(512);
        xfer(8'hFF, r);
        chk(r == 8'hFF, "R5 gap byte", r, 8'hFF);
        chk(!in_cmd_mode, "R5 chained, not cmd mode", in_cmd_mode, 0);
        xfer(8'hFF, r);
        chk(r == 8'hFE, "R5 second token", r, 8'hFE);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] e = rd_base + rd_idx[7:0];
            xfer(8'hFF, r);
            chk(r == e, "R3 second block data", r, e);
        end
        i0 = rd_idx;
        xfer(8'h4C, r);
        chk(r == 8'hFF, "R6 abort reply data", r, 8'hFF);
        chk(rd_idx == i0, "R6 no pop on abort", rd_idx, i0);
        chk(in_cmd_mode, "R6 cmd mode after abort", in_cmd_mode, 1);
    endtask

    task automatic t_single_full();
        start_read(1'b1);
        read_block(512);
        chk(in_cmd_mode, "R5 single full block ends", in_cmd_mode, 1);
    endtask

    task automatic t_abort_token();
        logic [7:0] r;
        int a0 = abort_cnt;
        start_read(1'b0);
        xfer(8'h4C, r);
        chk(r == 8'hFF, "R6 abort reply token", r, 8'hFF);
        chk(abort_cnt == a0 + 1, "R6 abort pulse token", abort_cnt, a0 + 1);
        chk(in_cmd_mode, "R6 cmd after token abort", in_cmd_mode, 1);
    endtask

    task automatic t_abort_crc();
        logic [7:0] r;
        int a0 = abort_cnt;
        rd_stop = rd_idx + 2;
        start_read(1'b0);
        xfer(8'hFF, r);
        xfer(8'hFF, r);
        xfer(8'hFF, r);
        xfer(8'hFF, r);   // crc high byte
        xfer(8'h4C, r);
        chk(r == 8'hFF, "R6 abort reply crc", r, 8'hFF);
        chk(abort_cnt == a0 + 1, "R6 abort pulse crc", abort_cnt, a0 + 1);
        chk(in_cmd_mode, "R6 cmd after crc abort", in_cmd_mode, 1);
        rd_stop = 0;
    endtask

    task automatic t_write(input logic [7:0] tok, input int n);
        logic [7:0] r;
        int w0 = wr_cnt;
        int a0 = abort_cnt;
        int bad = 0;
        wr_stop = (n < 512) ? wr_cnt + n : 0;
        xfer(tok, r);
        chk(r == 8'hFF, "R7 token reply", r, 8'hFF);
        chk(!in_cmd_mode, "R7 write leaves cmd mode", in_cmd_mode, 0);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d = (k == 0) ? 8'h4C : 8'(k * 7 + 3);
            xfer(d, r);
            if (r != d) begin
                bad++;
                chk(1'b0, "R8 write echo", r, d);
            end
            if (wr_log[10'(w0 + k)] != d) begin
                bad++;
                chk(1'b0, "R8 write sink data", wr_log[10'(w0 + k)], d);
            end
        end
        chk(bad == 0, "R8 write block", bad, 0);
        chk(wr_cnt == w0 + n, "R8 write byte count", wr_cnt, w0 + n);
        chk(abort_cnt == a0, "R8 4C is data", abort_cnt, a0);
        xfer(8'h12, r); chk(r == 8'hFF, "R9 crc byte 1 reply", r, 8'hFF);
        xfer(8'h34, r); chk(r == 8'hFF, "R9 crc byte 2 reply", r, 8'hFF);
        chk(wr_cnt == w0 + n, "R9 crc not written", wr_cnt, w0 + n);
        xfer(8'hFF, r); chk(r == 8'h05, "R9 accepted", r, 8'h05);
        chk(in_cmd_mode, "R9 back to cmd mode", in_cmd_mode, 1);
        wr_stop = 0;
    endtask

    task automatic t_stop(input logic busy);
        logic [7:0] r;
        int s0 = stop_cnt;
        logic [7:0] e = busy ? 8'h00 : 8'hFF;
        be_busy = busy;
        xfer(8'hFD, r);
        chk(r == 8'hFF, "R10 stop token reply", r, 8'hFF);
        chk(stop_cnt == s0 + 1, "R10 stop pulse", stop_cnt, s0 + 1);
        xfer(8'hFF, r);
        chk(r == e, "R10 status byte", r, e);
        chk(in_cmd_mode, "R10 back to cmd mode", in_cmd_mode, 1);
        be_busy = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_short_read();
        t_multi_read();
        t_single_full();
        t_abort_token();
        t_abort_crc();
        t_write(8'hFE, 4);
        t_write(8'hFC, 512);
        t_stop(1'b1);
        t_stop(1'b0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        finish_run();
    end
endmodule